// File: doc/BRIEF.md
# Leap-Ahead Pseudo-Random Video Noise Generator

This block emits one 10-bit pseudo-random white-noise word per enabled clock, suited to streaming a noise pattern (for example a luma noise field) in raster order alongside a pixel-valid strobe. A 17-bit maximal-length shift register lies underneath. On every enabled clock the register is moved ten single-shift positions at once, through an unrolled combinational chain. The ten low bits of each new state are therefore all freshly generated, and consecutive output words never reuse a bit.

Ten and 2^17-1 share no common factor. Stepping ten positions at a time still visits every one of the 2^17-1 nonzero states before the sequence repeats. A seed port with a load strobe restarts the sequence from any state. An all-zero seed would lock the register, so it is replaced by the built-in default. Video timing, spectral shaping and amplitude scaling are handled by neighbouring logic.

Top module: `noise_leap_gen`

## Requirements
- R1: A synchronous reset sets the internal state to 17'h1ACE1, drives `noise_valid` to 0 and drives `noise_sample` to 0.
- R2: In each clock with `pix_en` high and `seed_load` low, the state advances by exactly ten single steps. A single step shifts the state one place toward the MSB and inserts bit16 XOR bit13 (polynomial x^17 + x^14 + 1) at bit 0.
- R3: `noise_sample` is a register holding bits [9:0] of the state as updated in the previous enabled clock. `noise_valid` equals `pix_en` delayed by one clock.
- R4: In a clock with `pix_en` low and `seed_load` low, the state holds, `noise_sample` holds and `noise_valid` is 0 in the next cycle.
- R5: `seed_load` takes priority over `pix_en`: the state becomes `seed_value` with no advance. If `pix_en` is also high, the next sample is bits [9:0] of the seed.
- R6: Loading an all-zero `seed_value` sets the state to 17'h1ACE1.
- R7: From any nonzero seed, the state first returns to that seed after exactly 131071 enabled clocks, and not earlier.
- R8: The state is never all-zero outside reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| pix_en | input | 1 | Clock enable: advance and emit a sample |
| seed_load | input | 1 | Load strobe for `seed_value` |
| seed_value | input | 17 | Seed to load |
| noise_sample | output | 10 | Registered noise word |
| noise_valid | output | 1 | `pix_en` delayed by one clock |

## Verification
Seeding and advancing can be requested in the same clock. The bench raises `seed_load` together with `pix_en`, once with a nonzero seed and once with a zero seed. In both cases the following sample must equal the low bits of the loaded (or substituted default) state, not of a leap from it. The reference model applies the single step ten times per enabled clock and is compared against every output word. One full period is run from a loaded seed, and the model's first return to the seed must fall on exactly the 131071st enabled clock.

// File: rtl/noise_leap_pkg.sv
package noise_leap_pkg;

   // Source selected for the next state register value
   typedef enum logic [1:0] {
      SRC_HOLD = 2'd0,
      SRC_SEED = 2'd1,
      SRC_LEAP = 2'd2
   } state_src_e;

   localparam int unsigned DEF_STATE_W = 17;
   localparam int unsigned DEF_OUT_W   = 10;
   localparam int unsigned DEF_LEAP    = 10;
   localparam int unsigned DEF_TAP_HI  = 16;
   localparam int unsigned DEF_TAP_LO  = 13;

endpackage

// File: rtl/noise_leap_chain.sv
module noise_leap_chain #(
   parameter int unsigned STATE_W = 17,
   parameter int unsigned TAP_HI  = 16,
   parameter int unsigned TAP_LO  = 13,
   parameter int unsigned LEAP    = 10
) (
   input  logic [STATE_W-1:0] cur_state,
   output logic [STATE_W-1:0] leap_state
);

   generate
      if (STATE_W < 3) begin : g_bad_w
         $error("noise_leap_chain: STATE_W must be at least 3");
      end
      if (TAP_HI != STATE_W - 1) begin : g_bad_hi
         $error("noise_leap_chain: TAP_HI must be the MSB of the state");
      end
      if (TAP_LO >= TAP_HI) begin : g_bad_lo
         $error("noise_leap_chain: TAP_LO must lie below TAP_HI");
      end
      if (LEAP < 1) begin : g_bad_leap
         $error("noise_leap_chain: LEAP must be at least 1");
      end
   endgenerate

   generate
      if (LEAP == 1) begin : g_single
         // R2: one shift per clock
         assign leap_state = {cur_state[STATE_W-2:0],
                              cur_state[TAP_HI] ^ cur_state[TAP_LO]};
      end else begin : g_unrolled
         // R2: unrolled chain of single shifts, collapsed to XOR logic
         logic [STATE_W-1:0] stage [0:LEAP];
         assign stage[0] = cur_state;
         for (genvar s = 0; s < LEAP; s++) begin : g_stage
            assign stage[s+1] = {stage[s][STATE_W-2:0],
                                 stage[s][TAP_HI] ^ stage[s][TAP_LO]};
         end
         assign leap_state = stage[LEAP];
      end
   endgenerate

endmodule

// File: rtl/noise_seed_guard.sv
module noise_seed_guard #(
   parameter int unsigned          STATE_W      = 17,
   parameter logic [STATE_W-1:0]   DEFAULT_SEED = 17'h1ACE1
) (
   input  logic [STATE_W-1:0] raw_seed,
   output logic [STATE_W-1:0] safe_seed
);

   generate
      if (DEFAULT_SEED == '0) begin : g_bad_seed
         $error("noise_seed_guard: DEFAULT_SEED must be nonzero");
      end
   endgenerate

   // R6: a zero seed would freeze the register; substitute the default
   always_comb begin
      if (raw_seed == '0) safe_seed = DEFAULT_SEED;
      else                safe_seed = raw_seed;
   end

   // R8
   always_comb begin
      safe_seed_nonzero_chk: assert (safe_seed != '0 || $isunknown(raw_seed));
   end

endmodule

// File: rtl/noise_sample_stage.sv
module noise_sample_stage #(
   parameter int unsigned STATE_W = 17,
   parameter int unsigned OUT_W   = 10
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               take,
   input  logic [STATE_W-1:0] fresh_state,
   output logic [OUT_W-1:0]   sample_q,
   output logic               valid_q
);

   generate
      if (OUT_W < 1 || OUT_W > STATE_W) begin : g_bad_out
         $error("noise_sample_stage: OUT_W must be 1..STATE_W");
      end
   endgenerate

   // R3: register the low bits of the updated state; valid trails take
   always_ff @(posedge clk) begin
      if (rst) begin
         sample_q <= '0;
         valid_q  <= 1'b0;
      end else begin
         valid_q <= take;
         if (take) sample_q <= fresh_state[OUT_W-1:0];
      end
   end

   // R3
   valid_follows_take_chk: assert property (@(posedge clk) disable iff (rst)
      take |=> valid_q);
   // R4
   idle_sample_hold_chk: assert property (@(posedge clk) disable iff (rst)
      !take |=> (!valid_q && $stable(sample_q)));

endmodule

// File: rtl/noise_leap_gen.sv
module noise_leap_gen
   import noise_leap_pkg::*;
#(
   parameter int unsigned        STATE_W      = DEF_STATE_W,
   parameter int unsigned        TAP_HI       = DEF_TAP_HI,
   parameter int unsigned        TAP_LO       = DEF_TAP_LO,
   parameter int unsigned        LEAP         = DEF_LEAP,
   parameter int unsigned        OUT_W        = DEF_OUT_W,
   parameter logic [STATE_W-1:0] DEFAULT_SEED = 17'h1ACE1
) (
   input  logic               clk,
   input  logic               rst,
   input  logic               pix_en,
   input  logic               seed_load,
   input  logic [STATE_W-1:0] seed_value,
   output logic [OUT_W-1:0]   noise_sample,
   output logic               noise_valid
);

   generate
      if (LEAP < OUT_W) begin : g_overlap_warn
         $error("noise_leap_gen: LEAP below OUT_W lets samples share bits");
      end
   endgenerate

   logic [STATE_W-1:0] state_q;
   logic [STATE_W-1:0] state_d;
   logic [STATE_W-1:0] leap_next;
   logic [STATE_W-1:0] seed_safe;
   state_src_e         src_sel;

   noise_leap_chain #(
      .STATE_W (STATE_W),
      .TAP_HI  (TAP_HI),
      .TAP_LO  (TAP_LO),
      .LEAP    (LEAP)
   ) chain_i (
      .cur_state  (state_q),
      .leap_state (leap_next)
   );

   noise_seed_guard #(
      .STATE_W      (STATE_W),
      .DEFAULT_SEED (DEFAULT_SEED)
   ) guard_i (
      .raw_seed  (seed_value),
      .safe_seed (seed_safe)
   );

   // R5: seeding outranks advancing
   always_comb begin
      if (seed_load)   src_sel = SRC_SEED;
      else if (pix_en) src_sel = SRC_LEAP;
      else             src_sel = SRC_HOLD;
   end

   always_comb begin
      unique case (src_sel)
         SRC_SEED: state_d = seed_safe;
         SRC_LEAP: state_d = leap_next;
         default:  state_d = state_q;
      endcase
   end

   // R1: reset loads the default seed
   always_ff @(posedge clk) begin
      if (rst) state_q <= DEFAULT_SEED;
      else     state_q <= state_d;
   end

   noise_sample_stage #(
      .STATE_W (STATE_W),
      .OUT_W   (OUT_W)
   ) out_i (
      .clk         (clk),
      .rst         (rst),
      .take        (pix_en),
      .fresh_state (state_d),
      .sample_q    (noise_sample),
      .valid_q     (noise_valid)
   );

   // R8
   state_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
      state_q != '0);
   // R4
   idle_state_hold_chk: assert property (@(posedge clk) disable iff (rst)
      (!pix_en && !seed_load) |=> $stable(state_q));
   // R5
   load_wins_chk: assert property (@(posedge clk) disable iff (rst)
      (seed_load && seed_value != '0) |=> state_q == $past(seed_value));
   // R6
   zero_seed_default_chk: assert property (@(posedge clk) disable iff (rst)
      (seed_load && seed_value == '0) |=> state_q == DEFAULT_SEED);
   // R3
   sample_matches_state_chk: assert property (@(posedge clk) disable iff (rst)
      pix_en |=> noise_sample == state_q[OUT_W-1:0]);

endmodule

// File: tb/noise_leap_gen_tb_top.sv
`timescale 1ns/100ps
module noise_leap_gen_tb_top;

   localparam logic [16:0] DEF = 17'h1ACE1;
   localparam int PERIOD = 131071;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic        pix_en = 1'b0;
   logic        seed_load = 1'b0;
   logic [16:0] seed_value = '0;
   logic [9:0]  noise_sample;
   logic        noise_valid;

   always #2.5 clk = ~clk;

   noise_leap_gen dut_i (
      .clk          (clk),
      .rst          (rst),
      .pix_en       (pix_en),
      .seed_load    (seed_load),
      .seed_value   (seed_value),
      .noise_sample (noise_sample),
      .noise_valid  (noise_valid)
   );

   int    checks = 0;
   int    fails  = 0;
   bit    done   = 1'b0;
   logic [16:0] mstate = DEF;
   logic [9:0]  msample = '0;
   logic [10:0] q_exp [$];
   string       q_tag [$];

   function automatic logic [16:0] ref_step(input logic [16:0] s);
      return {s[15:0], s[16] ^ s[13]};
   endfunction

   function automatic logic [16:0] ref_leap(input logic [16:0] s);
      logic [16:0] t = s;
      for (int k = 0; k < 10; k++) t = ref_step(t);
      return t;
   endfunction

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", tag, act, exp);
      end
   endtask

   task automatic drive(input logic en, input logic ld, input logic [16:0] sd, input string tag);
      @(negedge clk);
      pix_en = en; seed_load = ld; seed_value = sd;
      if (ld)      mstate = (sd == '0) ? DEF : sd;
      else if (en) mstate = ref_leap(mstate);
      if (en) msample = mstate[9:0];
      q_exp.push_back({en, msample});
      q_tag.push_back(tag);
   endtask

   // Monitor: compare each result after the edge that produced it
   always @(posedge clk) begin
      #1;
      if (q_exp.size() > 0) begin
         logic [10:0] e;
         string t;
         e = q_exp.pop_front();
         t = q_tag.pop_front();
         check(t, {21'd0, noise_valid, noise_sample}, {21'd0, e});
      end
   end

   task automatic summary();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
   endtask

   initial begin
      repeat (190000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired");
         summary();
         $finish;
      end
   end

   initial begin
      int first_ret;
      logic [16:0] walk;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst = 1'b0;
      // R1: reset state at the ports
      check("R1 reset valid", {31'd0, noise_valid}, 32'd0);
      check("R1 reset sample", {22'd0, noise_sample}, 32'd0);
      // R1/R2: first sample comes from the default seed
      drive(1'b1, 1'b0, '0, "R1 first leap from default");
      for (int i = 0; i < 24; i++) drive(1'b1, 1'b0, '0, "R2 R3 leap stream");
      // R4: gaps in the enable
      for (int i = 0; i < 16; i++) drive(i[0], 1'b0, '0, "R4 alternating enable");
      for (int i = 0; i < 4; i++) drive(1'b0, 1'b0, '0, "R4 idle hold");
      drive(1'b1, 1'b0, '0, "R4 resume after idle");
      // R5: load with and without enable
      drive(1'b1, 1'b1, 17'h0BEEF, "R5 load with enable");
      drive(1'b1, 1'b0, '0, "R5 leap from loaded seed");
      drive(1'b0, 1'b1, 17'h12345, "R5 load while idle");
      drive(1'b1, 1'b0, '0, "R5 leap after idle load");
      // R6: zero seed
      drive(1'b1, 1'b1, 17'h00000, "R6 zero seed with enable");
      drive(1'b1, 1'b0, '0, "R6 leap after zero seed");
      drive(1'b0, 1'b1, 17'h00000, "R6 zero seed idle");
      drive(1'b1, 1'b0, '0, "R6 leap from substituted default");
      // R7: full period from a loaded seed
      drive(1'b0, 1'b1, 17'h00001, "R7 load period seed");
      first_ret = 0;
      walk = 17'h00001;
      for (int i = 1; i <= PERIOD; i++) begin
         walk = ref_leap(walk);
         if (first_ret == 0 && walk == 17'h00001) first_ret = i;
         drive(1'b1, 1'b0, '0, "R7 period walk");
      end
      check("R7 first return index", first_ret, PERIOD);
      drive(1'b0, 1'b0, '0, "R7 settle");
      @(negedge clk);
      check("R7 sample at period end", {22'd0, noise_sample}, 32'h001);
      drive(1'b1, 1'b0, '0, "R7 wraps to second leap");
      @(negedge clk);
      @(negedge clk);
      done = 1'b1;
      summary();
      $finish;
   end

endmodule